// File: doc/BRIEF.md
# Two-Level DMA Address Translator

This block sits between DMA-capable devices and the memory system. It turns a device bus address into a physical address by walking a two-level page table. The first level is a bank of 64 on-chip 32-bit entries, written through a small register port. The second level is a table of 32-bit entries in memory, read one word at a time over a request/response port. Each first-level entry covers 32 MiB of bus space (8192 second-level entries of 4 KiB pages). A first-level entry can also be marked as a big page, in which case it maps its whole 32 MiB span directly, with no memory read.

Finished translations are kept in a small fully associative TLB, so a repeated page is answered on the next cycle without touching memory. Software controls the block through the register port. It writes first-level entries, picks the translation window size, turns translation on or off, and drops cached pages by 16 KiB region. When translation is off, addresses pass straight through. An address outside the window, or one that hits an invalid entry at either level, returns a fault. The caching and priority hints carried by the entries are passed out with each response.

The control is a three-state machine. `W_IDLE` accepts requests and answers bypass, fault, TLB-hit and big-page cases directly. A TLB miss through a normal first-level entry takes the IDLE-to-FETCH transition into `W_FETCH`, which holds the memory read request until it is accepted. The FETCH-to-WAIT transition then leads to `W_WAIT`, which waits for the memory word. The WAIT-to-IDLE transition delivers the walk result.

Top module: `iova_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, translation is off, every first-level entry is invalid and the TLB is empty.
- R2: The register port decodes `cfg_addr` 0..63 as first-level entries, 64 as the window register (window code in bits 1:0), 65 as the command register (translation enable in bit 8) and 66 as the invalidate register. Each write takes effect from the next cycle.
- R3: When the enable bit is clear, an accepted request is answered in the next cycle. The answer has no fault, `rsp_pa` equal to the zero-extended bus address and both hints 0. No memory read is made and the TLB is not touched.
- R4: Window code 0 accepts bus addresses below 256 MiB, code 1 below 2 GiB and code 3 below 128 GiB. Code 2 accepts nothing. A translated request outside the window faults in the next cycle.
- R5: The first-level index is bus address bits 30:25. Higher address bits play no part in indexing. Bit 30 of the entry means valid; a request through an invalid entry faults in the next cycle with no memory read.
- R6: A first-level entry with bits 31 and 30 both set is a big page. It is answered in the next cycle with page number {entry[29:2],00} + address[24:12], cached hint = entry bit 1 and priority hint = entry bit 0, and no memory read.
- R7: For a normal entry (bit 31 clear) on a TLB miss, exactly one memory read is issued, at {entry[29:0], 12'h000} + 4 × address[24:12]. The request is held with a stable address until accepted.
- R8: A second-level word has valid in bit 31, the cached hint in bit 30 and the page number in bits 29:0; its priority hint is 0. The physical address is {page number, address[11:0]}. An invalid word gives a fault.
- R9: A fault response has `rsp_fault` = 1, `rsp_pa` = 0 and both hints 0. It lasts one cycle and caches nothing.
- R10: The TLB has 8 entries and fills only on a successful walk or big-page translation, replacing round-robin. A hit is answered in the next cycle without a memory read.
- R11: A write of value V to the invalidate register drops every cached page whose bus address shifted right by 14 equals V; other pages stay cached. If the write hits the page of a walk in progress, the walk result is still returned but not cached.
- R12: Only one walk is outstanding: `req_ready` stays 0 from the acceptance of a walking request until its response cycle.
- R13: The enable bit and the window are checked on every request before the TLB, so a cached page outside a newly narrowed window faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register select |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translation request accepted when high with valid |
| req_addr | input | 40 | Device bus address |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_fault | output | 1 | Translation failed |
| rsp_pa | output | 42 | Physical address (0 on fault) |
| rsp_cached | output | 1 | Cached hint from the entry |
| rsp_prio | output | 1 | Priority hint from a big-page entry |
| mem_req_valid | output | 1 | Second-level table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 42 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Table word returned |
| mem_rsp_data | input | 32 | Table word |

## Verification
The bench targets these corner cases, each with the fault a broken design would show:
- Repeated requests to a cached page, counted against the memory read count. A TLB that never hits would show extra reads, and a late answer would arrive after the next cycle.
- A region invalidate that must drop two cached pages in the same 16 KiB while sparing a neighbour. A wrong shift would drop the wrong pages.
- An invalidate that lands in the middle of a walk. A design that ignores it would cache a stale page and answer later repeats without reading memory.
- The round-robin eviction after nine fills. Other replacement orders would evict the wrong entry.
- The 128 GiB window, whose addresses above 2 GiB alias the same first-level entries.
- Narrowing the window over a cached page. A design that checks the TLB first would answer instead of faulting.

// File: rtl/iova_pkg.sv
package iova_pkg;

    localparam int unsigned PAGE_SH   = 12;
    localparam int unsigned L1_LSB    = 25;
    localparam int unsigned L2_IW     = L1_LSB - PAGE_SH;
    localparam int unsigned INV_SH    = 14;

    // register selects (above the first-level bank)
    localparam logic [6:0] SEL_WINDOW = 7'd64;
    localparam logic [6:0] SEL_CMD    = 7'd65;
    localparam logic [6:0] SEL_INVAL  = 7'd66;

    localparam int unsigned EN_BIT    = 8;

    typedef enum logic [1:0] {
        W_IDLE,
        W_FETCH,
        W_WAIT
    } walk_state_e;

    typedef enum logic [2:0] {
        K_BYPASS,
        K_FAULT,
        K_HIT,
        K_BIG,
        K_WALK
    } req_kind_e;

endpackage

// File: rtl/iova_cfg_regs.sv
module iova_cfg_regs
    import iova_pkg::*;
#(
    parameter int unsigned L1_N   = 64,
    parameter int unsigned CFG_AW = 7,
    parameter int unsigned INV_W  = 26
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [31:0]              cfg_wdata,
    input  logic [$clog2(L1_N)-1:0]  l1_idx,
    output logic [31:0]              l1_entry,
    output logic [1:0]               win_code,
    output logic                     xl_en,
    output logic                     inv_en,
    output logic [INV_W-1:0]         inv_region
);

    localparam int unsigned IW = $clog2(L1_N);

    logic [31:0] l1_q [L1_N];

    for (genvar g = 0; g < L1_N; g++) begin : g_l1
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                l1_q[g] <= '0;
            end else if (cfg_we && cfg_addr == CFG_AW'(g)) begin
                l1_q[g] <= cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_code <= 2'd0;
            xl_en    <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_addr == SEL_WINDOW) win_code <= cfg_wdata[1:0];
            if (cfg_addr == SEL_CMD)    xl_en    <= cfg_wdata[EN_BIT];
        end
    end

    assign l1_entry   = l1_q[l1_idx[IW-1:0]];
    assign inv_en     = cfg_we && (cfg_addr == SEL_INVAL);
    assign inv_region = cfg_wdata[INV_W-1:0];

endmodule

// File: rtl/iova_tlb.sv
module iova_tlb #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned TAG_W   = 28,
    parameter int unsigned DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              inv_en,
    input  logic [TAG_W-3:0]  inv_region
);

    localparam int unsigned PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [DATA_W-1:0]  data_q [ENTRIES];
    logic [PW-1:0]      rr_q;
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign match[g] = vld_q[g] && (tag_q[g] == lk_tag);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g]  <= 1'b0;
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else begin
                if (inv_en && tag_q[g][TAG_W-1:2] == inv_region) begin
                    vld_q[g] <= 1'b0;
                end
                if (fill_en && rr_q == PW'(g)) begin
                    vld_q[g]  <= 1'b1;
                    tag_q[g]  <= fill_tag;
                    data_q[g] <= fill_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (fill_en) begin
            rr_q <= (rr_q == PW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    always_comb begin
        lk_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_data = lk_data | data_q[i];
        end
    end

    assign lk_hit = |match;

endmodule

// File: rtl/iova_walk_fsm.sv
module iova_walk_fsm
    import iova_pkg::*;
#(
    parameter int unsigned BUS_AW = 40,
    parameter int unsigned PPN_W  = 30,
    parameter int unsigned PA_AW  = PPN_W + PAGE_SH,
    parameter int unsigned TAG_W  = BUS_AW - PAGE_SH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [BUS_AW-1:0]  req_addr,
    input  logic               xl_en,
    input  logic [1:0]         win_code,
    input  logic [31:0]        l1_entry,
    input  logic               tlb_hit,
    input  logic [PPN_W+1:0]   tlb_data,
    input  logic               inv_en,
    input  logic [TAG_W-3:0]   inv_region,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_AW-1:0]   mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [31:0]        mem_rsp_data,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [PA_AW-1:0]   rsp_pa,
    output logic               rsp_cached,
    output logic               rsp_prio,
    output logic               fill_en,
    output logic [TAG_W-1:0]   fill_tag,
    output logic [PPN_W+1:0]   fill_data
);

    walk_state_e state_q, state_d;
    req_kind_e   kind;

    logic                in_win;
    logic                accept;
    logic [TAG_W-1:0]    req_tag;
    logic [PPN_W-1:0]    big_ppn;
    logic                req_inv_hit;
    logic                walk_inv_hit;
    logic                walk_done;

    logic [TAG_W-1:0]    w_tag_q;
    logic [PAGE_SH-1:0]  w_off_q;
    logic [PA_AW-1:0]    w_addr_q;
    logic                w_kill_q;

    assign req_tag = req_addr[BUS_AW-1:PAGE_SH];
    assign accept  = req_valid && req_ready;

    // window test, base at zero
    always_comb begin
        unique case (win_code)
            2'd0:    in_win = (req_addr >> 28) == '0;
            2'd1:    in_win = (req_addr >> 31) == '0;
            2'd3:    in_win = (req_addr >> 37) == '0;
            default: in_win = 1'b0;
        endcase
    end

    always_comb begin
        if (!xl_en)              kind = K_BYPASS;
        else if (!in_win)        kind = K_FAULT;
        else if (tlb_hit)        kind = K_HIT;
        else if (!l1_entry[30])  kind = K_FAULT;
        else if (l1_entry[31])   kind = K_BIG;
        else                     kind = K_WALK;
    end

    assign big_ppn = {l1_entry[PPN_W-1:2], 2'b00}
                   + PPN_W'(req_addr[L1_LSB-1:PAGE_SH]);

    assign req_inv_hit  = inv_en && (req_tag[TAG_W-1:2] == inv_region);
    assign walk_inv_hit = inv_en && (w_tag_q[TAG_W-1:2] == inv_region);
    assign walk_done    = (state_q == W_WAIT) && mem_rsp_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d       = state_q;
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        unique case (state_q)
            W_IDLE: begin
                req_ready = 1'b1;
                if (req_valid && kind == K_WALK) state_d = W_FETCH;
            end
            W_FETCH: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) state_d = W_WAIT;
            end
            W_WAIT: begin
                if (mem_rsp_valid) state_d = W_IDLE;
            end
            default: state_d = W_IDLE;
        endcase
    end

    assign mem_req_addr = w_addr_q;

    // walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_tag_q  <= '0;
            w_off_q  <= '0;
            w_addr_q <= '0;
            w_kill_q <= 1'b0;
        end else if (accept && kind == K_WALK) begin
            w_tag_q  <= req_tag;
            w_off_q  <= req_addr[PAGE_SH-1:0];
            w_addr_q <= {l1_entry[PPN_W-1:0], {PAGE_SH{1'b0}}}
                      + PA_AW'({req_addr[L1_LSB-1:PAGE_SH], 2'b00});
            w_kill_q <= req_inv_hit;
        end else if (state_q != W_IDLE && walk_inv_hit) begin
            w_kill_q <= 1'b1;
        end
    end

    // response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_pa     <= '0;
            rsp_cached <= 1'b0;
            rsp_prio   <= 1'b0;
        end else begin
            rsp_valid  <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_pa     <= '0;
            rsp_cached <= 1'b0;
            rsp_prio   <= 1'b0;
            if (accept && kind != K_WALK) begin
                rsp_valid <= 1'b1;
                unique case (kind)
                    K_BYPASS: rsp_pa <= PA_AW'(req_addr);
                    K_HIT: begin
                        rsp_pa     <= {tlb_data[PPN_W+1:2], req_addr[PAGE_SH-1:0]};
                        rsp_cached <= tlb_data[1];
                        rsp_prio   <= tlb_data[0];
                    end
                    K_BIG: begin
                        rsp_pa     <= {big_ppn, req_addr[PAGE_SH-1:0]};
                        rsp_cached <= l1_entry[1];
                        rsp_prio   <= l1_entry[0];
                    end
                    default: rsp_fault <= 1'b1;
                endcase
            end else if (walk_done) begin
                rsp_valid <= 1'b1;
                if (mem_rsp_data[31]) begin
                    rsp_pa     <= {mem_rsp_data[PPN_W-1:0], w_off_q};
                    rsp_cached <= mem_rsp_data[30];
                end else begin
                    rsp_fault  <= 1'b1;
                end
            end
        end
    end

    // TLB fill on successful translations only
    always_comb begin
        fill_en   = 1'b0;
        fill_tag  = req_tag;
        fill_data = {big_ppn, l1_entry[1], l1_entry[0]};
        if (accept && kind == K_BIG && !req_inv_hit) begin
            fill_en = 1'b1;
        end else if (walk_done && mem_rsp_data[31] && !w_kill_q && !walk_inv_hit) begin
            fill_en   = 1'b1;
            fill_tag  = w_tag_q;
            fill_data = {mem_rsp_data[PPN_W-1:0], mem_rsp_data[30], 1'b0};
        end
    end

endmodule

// File: rtl/iova_xlate.sv
module iova_xlate
    import iova_pkg::*;
#(
    parameter int unsigned BUS_AW = 40,
    parameter int unsigned PPN_W  = 30,
    parameter int unsigned TLB_N  = 8,
    parameter int unsigned L1_N   = 64,
    localparam int unsigned PA_AW  = PPN_W + PAGE_SH,
    localparam int unsigned CFG_AW = $clog2(L1_N) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [31:0]        cfg_wdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [BUS_AW-1:0]  req_addr,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [PA_AW-1:0]   rsp_pa,
    output logic               rsp_cached,
    output logic               rsp_prio,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_AW-1:0]   mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [31:0]        mem_rsp_data
);

    localparam int unsigned TAG_W = BUS_AW - PAGE_SH;
    localparam int unsigned L1_IW = $clog2(L1_N);

    logic [31:0]        l1_entry;
    logic [1:0]         win_code;
    logic               xl_en;
    logic               inv_en;
    logic [TAG_W-3:0]   inv_region;
    logic               tlb_hit;
    logic [PPN_W+1:0]   tlb_data;
    logic               fill_en;
    logic [TAG_W-1:0]   fill_tag;
    logic [PPN_W+1:0]   fill_data;

    iova_cfg_regs #(
        .L1_N   (L1_N),
        .CFG_AW (CFG_AW),
        .INV_W  (TAG_W - 2)
    ) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .l1_idx     (req_addr[L1_LSB+L1_IW-1:L1_LSB]),
        .l1_entry   (l1_entry),
        .win_code   (win_code),
        .xl_en      (xl_en),
        .inv_en     (inv_en),
        .inv_region (inv_region)
    );

    iova_tlb #(
        .ENTRIES (TLB_N),
        .TAG_W   (TAG_W),
        .DATA_W  (PPN_W + 2)
    ) tlb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_tag     (req_addr[BUS_AW-1:PAGE_SH]),
        .lk_hit     (tlb_hit),
        .lk_data    (tlb_data),
        .fill_en    (fill_en),
        .fill_tag   (fill_tag),
        .fill_data  (fill_data),
        .inv_en     (inv_en),
        .inv_region (inv_region)
    );

    iova_walk_fsm #(
        .BUS_AW (BUS_AW),
        .PPN_W  (PPN_W),
        .PA_AW  (PA_AW),
        .TAG_W  (TAG_W)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .xl_en         (xl_en),
        .win_code      (win_code),
        .l1_entry      (l1_entry),
        .tlb_hit       (tlb_hit),
        .tlb_data      (tlb_data),
        .inv_en        (inv_en),
        .inv_region    (inv_region),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_fault     (rsp_fault),
        .rsp_pa        (rsp_pa),
        .rsp_cached    (rsp_cached),
        .rsp_prio      (rsp_prio),
        .fill_en       (fill_en),
        .fill_tag      (fill_tag),
        .fill_data     (fill_data)
    );

endmodule

// File: rtl/iova_xlate_chk.sv
module iova_xlate_chk #(
    parameter int unsigned BUS_AW = 40,
    parameter int unsigned PA_AW  = 42
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [BUS_AW-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [PA_AW-1:0]  rsp_pa,
    input logic              rsp_cached,
    input logic              rsp_prio,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [PA_AW-1:0]  mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              xl_en
);

    assert_fault_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && rsp_pa == '0 && !rsp_cached && !rsp_prio));

    assert_fetch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_one_walk_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xl_en) |=>
            (rsp_valid && !rsp_fault && rsp_pa == PA_AW'($past(req_addr))));

    assert_rsp_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rsp_valid)));

endmodule

bind iova_xlate iova_xlate_chk #(
    .BUS_AW (BUS_AW),
    .PA_AW  (PA_AW)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_pa        (rsp_pa),
    .rsp_cached    (rsp_cached),
    .rsp_prio      (rsp_prio),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .xl_en         (xl_en)
);

// File: tb/iova_xlate_tb.sv
module iova_xlate_tb_top;

    localparam int BUS_AW = 40;
    localparam int PA_AW  = 42;

    typedef struct {
        logic             fault;
        logic [PA_AW-1:0] pa;
        logic             cached;
        logic             prio;
        string            tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [6:0]        cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [BUS_AW-1:0] req_addr = '0;
    logic              rsp_valid, rsp_fault, rsp_cached, rsp_prio;
    logic [PA_AW-1:0]  rsp_pa;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [PA_AW-1:0]  mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [31:0]       mem_rsp_data = '0;

    int checks = 0;
    int fails  = 0;
    int mem_reads = 0;
    logic [PA_AW-1:0] last_fetch = '0;
    exp_t sb_q[$];
    logic [31:0] mem_tbl [logic [PA_AW-1:0]];

    always #10 clk = ~clk;

    iova_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_pa(rsp_pa), .rsp_cached(rsp_cached), .rsp_prio(rsp_prio),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    // memory model: ready toggles every cycle, word returns a few cycles later
    logic             pend = 1'b0;
    int               pend_cnt = 0;
    logic [PA_AW-1:0] pend_addr = '0;
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_req_ready <= rst_n ? ~mem_req_ready : 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            pend       <= 1'b1;
            pend_cnt   <= 2;
            pend_addr  <= mem_req_addr;
            last_fetch <= mem_req_addr;
            mem_reads  <= mem_reads + 1;
        end else if (pend) begin
            if (pend_cnt == 0) begin
                pend          <= 1'b0;
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem_tbl.exists(pend_addr) ? mem_tbl[pend_addr] : 32'h0;
            end else begin
                pend_cnt <= pend_cnt - 1;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop and compare every response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "unexpected response R10", 64'(rsp_pa), 64'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(rsp_fault == e.fault, {e.tag, " fault"}, 64'(rsp_fault), 64'(e.fault));
                chk(rsp_pa == e.pa, {e.tag, " pa"}, 64'(rsp_pa), 64'(e.pa));
                chk({rsp_cached, rsp_prio} == {e.cached, e.prio}, {e.tag, " hints"},
                    64'({rsp_cached, rsp_prio}), 64'({e.cached, e.prio}));
            end
        end
    end

    task automatic cfg_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [PA_AW-1:0] mk_pa(input logic [29:0] ppn, input logic [11:0] off);
        return {ppn, off};
    endfunction

    // driver: push expectation, issue request, check latency and read count
    task automatic send(input logic [BUS_AW-1:0] a, input logic f, input logic [PA_AW-1:0] pa,
                        input logic c, input logic p, input logic fast, input int reads,
                        input string tag);
        exp_t e;
        int r0;
        e.fault = f; e.pa = pa; e.cached = c; e.prio = p; e.tag = tag;
        r0 = mem_reads;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (fast) chk(rsp_valid == 1'b1, {tag, " next-cycle"}, 64'(rsp_valid), 64'h1);
        else      chk(req_ready == 1'b0, {tag, " R12 busy"}, 64'(req_ready), 64'h0);
        wait (sb_q.size() == 0);
        @(negedge clk);
        chk(mem_reads - r0 == reads, {tag, " reads"}, 64'(mem_reads - r0), 64'(reads));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    localparam logic [BUS_AW-1:0] A_ADDR = 40'h00_0200_5034;
    localparam logic [BUS_AW-1:0] B_ADDR = 40'h00_0200_6000;
    localparam logic [BUS_AW-1:0] C_ADDR = 40'h00_0200_8000;

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'h1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'h0);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'h0);

        // R3 bypass while disabled
        send(40'h12_3456_789A, 1'b0, 42'h12_3456_789A, 1'b0, 1'b0, 1'b1, 0, "R3 bypass");

        // R2 program the tables
        mem_tbl[42'h10_0014] = 32'h800A_BCDE;
        mem_tbl[42'h10_0018] = 32'hC001_2345;
        mem_tbl[42'h10_0020] = 32'h8000_0888;
        mem_tbl[42'h20_0004] = 32'h8000_0777;
        for (int i = 16; i <= 30; i++) mem_tbl[42'h10_0000 + 42'(i * 4)] = 32'h8000_1000 + 32'(i);
        cfg_write(7'd1, 32'h4000_0100);
        cfg_write(7'd2, 32'hC000_5003);
        cfg_write(7'd8, 32'h4000_0200);
        cfg_write(7'd64, 32'h1);
        cfg_write(7'd65, 32'h100);

        // R7/R8 walk, then R10 hit
        send(A_ADDR, 1'b0, mk_pa(30'h0AB_CDE, 12'h034), 1'b0, 1'b0, 1'b0, 1, "R8 walk A");
        chk(last_fetch == 42'h10_0014, "R7 fetch address", 64'(last_fetch), 64'h10_0014);
        send(A_ADDR, 1'b0, mk_pa(30'h0AB_CDE, 12'h034), 1'b0, 1'b0, 1'b1, 0, "R10 hit A");

        // R6 big page
        send(40'h00_0400_37FF, 1'b0, mk_pa(30'h5003, 12'h7FF), 1'b1, 1'b1, 1'b1, 0, "R6 big page");

        // R5/R9 invalid first level, R8 invalid second level not cached
        send(40'h00_0600_0000, 1'b1, '0, 1'b0, 1'b0, 1'b1, 0, "R5 invalid L1");
        send(40'h00_0200_7000, 1'b1, '0, 1'b0, 1'b0, 1'b0, 1, "R8 invalid L2");
        send(40'h00_0200_7000, 1'b1, '0, 1'b0, 1'b0, 1'b0, 1, "R9 fault not cached");

        // R4 windows
        send(40'h00_8000_0000, 1'b1, '0, 1'b0, 1'b0, 1'b1, 0, "R4 outside 2G");
        cfg_write(7'd64, 32'h0);
        send(40'h00_1000_0000, 1'b1, '0, 1'b0, 1'b0, 1'b1, 0, "R4 outside 256M");
        send(A_ADDR, 1'b0, mk_pa(30'h0AB_CDE, 12'h034), 1'b0, 1'b0, 1'b1, 0, "R4 inside 256M");
        cfg_write(7'd64, 32'h3);
        send(A_ADDR | 40'h00_8000_0000, 1'b0, mk_pa(30'h0AB_CDE, 12'h034), 1'b0, 1'b0, 1'b0, 1,
             "R5 alias in 128G");
        cfg_write(7'd64, 32'h2);
        send(A_ADDR, 1'b1, '0, 1'b0, 1'b0, 1'b1, 0, "R4 code 2 rejects");

        // R13 window checked before TLB
        cfg_write(7'd64, 32'h1);
        send(40'h00_1000_1010, 1'b0, mk_pa(30'h777, 12'h010), 1'b0, 1'b0, 1'b0, 1, "R13 fill");
        cfg_write(7'd64, 32'h0);
        send(40'h00_1000_1010, 1'b1, '0, 1'b0, 1'b0, 1'b1, 0, "R13 narrowed window");
        cfg_write(7'd64, 32'h1);
        send(40'h00_1000_1010, 1'b0, mk_pa(30'h777, 12'h010), 1'b0, 1'b0, 1'b1, 0, "R13 hit again");

        // R11 region invalidate
        send(B_ADDR, 1'b0, mk_pa(30'h12345, 12'h000), 1'b1, 1'b0, 1'b0, 1, "R8 cached hint");
        send(C_ADDR, 1'b0, mk_pa(30'h888, 12'h000), 1'b0, 1'b0, 1'b0, 1, "R11 fill C");
        cfg_write(7'd66, 32'(A_ADDR >> 14));
        send(A_ADDR, 1'b0, mk_pa(30'h0AB_CDE, 12'h034), 1'b0, 1'b0, 1'b0, 1, "R11 A dropped");
        send(B_ADDR, 1'b0, mk_pa(30'h12345, 12'h000), 1'b1, 1'b0, 1'b0, 1, "R11 B dropped");
        send(C_ADDR, 1'b0, mk_pa(30'h888, 12'h000), 1'b0, 1'b0, 1'b1, 0, "R11 C kept");

        // R10 round-robin replacement
        for (int i = 16; i <= 23; i++)
            send(40'h00_0200_0000 | 40'(i << 12), 1'b0, mk_pa(30'h1000 + 30'(i), 12'h0),
                 1'b0, 1'b0, 1'b0, 1, "R10 rr fill");
        send(40'h00_0201_0000, 1'b0, mk_pa(30'h1010, 12'h0), 1'b0, 1'b0, 1'b1, 0, "R10 rr hit");
        send(40'h00_0201_8000, 1'b0, mk_pa(30'h1018, 12'h0), 1'b0, 1'b0, 1'b0, 1, "R10 rr evict");
        send(40'h00_0201_1000, 1'b0, mk_pa(30'h1011, 12'h0), 1'b0, 1'b0, 1'b1, 0, "R10 rr kept");
        send(40'h00_0201_0000, 1'b0, mk_pa(30'h1010, 12'h0), 1'b0, 1'b0, 1'b0, 1, "R10 rr oldest gone");

        // R11 invalidate during a walk
        fork
            send(40'h00_0201_E000, 1'b0, mk_pa(30'h101E, 12'h0), 1'b0, 1'b0, 1'b0, 1, "R11 mid-walk");
            begin
                repeat (2) @(negedge clk);
                cfg_write(7'd66, 32'(40'h00_0201_E000 >> 14));
            end
        join
        send(40'h00_0201_E000, 1'b0, mk_pa(30'h101E, 12'h0), 1'b0, 1'b0, 1'b0, 1, "R11 not cached");

        // R3 disable again: cached page bypassed
        cfg_write(7'd65, 32'h0);
        send(C_ADDR, 1'b0, 42'(C_ADDR), 1'b0, 1'b0, 1'b1, 0, "R3 bypass after disable");

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule